// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves bytes between memory and peripherals on an 8-bit data bus without the processor taking part. It has four channels, each with a 16-bit current address and a 16-bit byte count. The processor programs every 16-bit value through an 8-bit register port. It writes the low byte first and the high byte next, and an internal byte pointer steers each write to the right half.

When a peripheral raises the request of an armed channel, the controller asks the processor for the bus with a hold request. It waits for the hold acknowledge, then picks a channel, with the lowest index winning. While the burst lasts, it drives that channel's address on the memory address bus and raises that channel's acknowledge to select the device. One byte moves per clock cycle. Each cycle pulses a memory strobe and an I/O strobe together, in the pairing that the channel's direction sets.

When the count runs out, the controller pulses terminal count during the final byte and releases the bus. The channel then stays disarmed until software writes its count again.

Top module: `dma4_ctrl`

## Requirements
- R1: While reset is high and after it is released, hold_req, dack, tc and all four strobes are low. Reset disarms every channel, so a raised dreq starts nothing until that channel's count is programmed. Reset clears the byte pointer to low and sets every channel to memory-to-device.
- R2: Register offsets: 2n is channel n's address and 2n+1 is its count, for n = 0..3. Offset 8 is the direction register, where bit n = 1 makes channel n device-to-memory and bit n = 0 makes it memory-to-device. A write to offsets 9..15 changes nothing.
- R3: Every write to offsets 0..7 lands in the low byte when the byte pointer is low and in the high byte when it is high, and then toggles the pointer. Writes to offset 8 and above leave the pointer alone.
- R4: An armed channel's dreq raises hold_req in the next cycle. No dack and no strobe appear while hold_ack is low. The first transfer cycle follows the cycle in which hold_ack is sampled high with hold_req high.
- R5: A memory-to-device channel asserts mem_rd and io_wr together in each transfer cycle, and never mem_wr or io_rd.
- R6: A device-to-memory channel asserts io_rd and mem_wr together in each transfer cycle, and never mem_rd or io_wr.
- R7: Each transfer cycle moves one byte at the channel's current address. The address then increments, wrapping from FFFFh to 0000h, and the count decrements. A programmed count of N moves N+1 bytes.
- R8: tc is high exactly during the cycle that moves the byte taken at count 0. In the next cycle hold_req and dack are low. The channel then ignores its dreq until a high-byte write to its count register re-arms it.
- R9: When several armed channels request at the moment the bus is granted, the lowest-numbered one is served first and keeps the bus until its burst ends.
- R10: If the active channel's dreq is low at the end of a transfer cycle, the bus is released: hold_req is low in the next cycle. The channel keeps its address and count, and resumes from there on a later request.
- R11: At most one dack bit is high at a time. A dack bit is high exactly in the cycles where a strobe pair is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| dreq | input | 4 | Per-channel transfer request from peripherals |
| dack | output | 4 | Per-channel acknowledge, selects the device |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | 16 | Memory address during transfer cycles, else zero |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal-count pulse on the final byte |

## Verification
The main sweep runs every channel in both directions. It uses counts of 0, 1 and 3 from start addresses just below FFFFh, so that single-byte bursts, short bursts and address wrap are each separated from an off-by-one in the byte count or the tc position. Paired simultaneous requests (1 with 3, 0 with 2) and a late request arriving while the grant is still withheld tell fixed priority at grant time apart from priority at request time. Direction writes and unused-offset writes placed between the two bytes of an address show whether the pointer toggles only on address and count writes. A mid-burst request drop, and a re-arm by count write after terminal count, show that progress is kept and that the disarm is lifted only by the high count byte.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_XFER = 2'd2
    } seq_e;

    typedef enum logic {
        DIR_MEM2DEV = 1'b0,
        DIR_DEV2MEM = 1'b1
    } dir_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobe_t;

    // One memory strobe and one I/O strobe per byte, paired by direction.
    function automatic strobe_t strobes_for(input dir_e d);
        strobe_t s;
        s = '0;
        if (d == DIR_MEM2DEV) begin
            s.mem_rd = 1'b1;
            s.io_wr  = 1'b1;
        end else begin
            s.io_rd  = 1'b1;
            s.mem_wr = 1'b1;
        end
        return s;
    endfunction

    function automatic int chan_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs #(
    parameter int NCH  = 4,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DW   = 8,
    parameter int OFFW = 4,
    parameter int CHW  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [OFFW-1:0]          wr_off,
    input  logic [DW-1:0]            wr_data,
    input  logic                     step,
    input  logic [CHW-1:0]           step_ch,
    output logic [NCH-1:0][AW-1:0]   addr_o,
    output logic [NCH-1:0][CW-1:0]   cnt_o,
    output logic [NCH-1:0]           dir_o,
    output logic [NCH-1:0]           mask_o
);
    localparam int MODE_OFF = 2 * NCH;
    localparam int AHI      = AW - DW;
    localparam int CHI      = CW - DW;

    logic           hi_q;
    logic [NCH-1:0] dir_q;
    logic           reg_wr;
    logic           mode_wr;

    assign reg_wr  = wr_en && (int'(wr_off) < MODE_OFF);
    assign mode_wr = wr_en && (wr_off == OFFW'(MODE_OFF));

    // Byte pointer and direction bits are shared by all channels.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= 1'b0;
            dir_q <= '0;
        end else begin
            if (reg_wr)
                hi_q <= ~hi_q;
            if (mode_wr)
                dir_q <= wr_data[NCH-1:0];
        end
    end

    assign dir_o = dir_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [AW-1:0] a_q;
        logic [CW-1:0] c_q;
        logic          m_q;
        logic          a_sel;
        logic          c_sel;
        logic          hit;

        assign a_sel = wr_en && (wr_off == OFFW'(2 * g));
        assign c_sel = wr_en && (wr_off == OFFW'(2 * g + 1));
        assign hit   = step && (step_ch == CHW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q <= '0;
                c_q <= '0;
                m_q <= 1'b1;
            end else begin
                if (a_sel) begin
                    if (hi_q)
                        a_q[AW-1:DW] <= wr_data[AHI-1:0];
                    else
                        a_q[DW-1:0] <= wr_data;
                end else if (hit) begin
                    a_q <= a_q + AW'(1);
                end

                if (c_sel) begin
                    if (hi_q) begin
                        c_q[CW-1:DW] <= wr_data[CHI-1:0];
                        m_q          <= 1'b0;
                    end else begin
                        c_q[DW-1:0] <= wr_data;
                    end
                end else if (hit) begin
                    c_q <= c_q - CW'(1);
                    if (c_q == '0)
                        m_q <= 1'b1;
                end
            end
        end

        assign addr_o[g] = a_q;
        assign cnt_o[g]  = c_q;
        assign mask_o[g] = m_q;
    end

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    // Lowest index wins: scan from the top so the last hit is the smallest.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i])
                idx = CHW'(i);
        end
    end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pend_any,
    input  logic [CHW-1:0] pend_idx,
    input  logic           hold_ack,
    input  logic           act_req,
    input  logic           act_last,
    output logic           hold_req,
    output logic           xfer,
    output logic [CHW-1:0] act_idx
);
    seq_e           st_q;
    logic [CHW-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            act_q <= '0;
        end else begin
            unique case (st_q)
                SEQ_IDLE: begin
                    if (pend_any)
                        st_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (!pend_any) begin
                        st_q <= SEQ_IDLE;
                    end else if (hold_ack) begin
                        st_q  <= SEQ_XFER;
                        act_q <= pend_idx;
                    end
                end
                SEQ_XFER: begin
                    if (act_last || !act_req)
                        st_q <= SEQ_IDLE;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign hold_req = (st_q != SEQ_IDLE);
    assign xfer     = (st_q == SEQ_XFER);
    assign act_idx  = act_q;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int  NCH  = 4,
    parameter int  AW   = 16,
    parameter int  CW   = 16,
    parameter int  DW   = 8,
    localparam int OFFW = $clog2(2 * NCH + 1),
    localparam int CHW  = chan_bits(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [OFFW-1:0] cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic [NCH-1:0]  dreq,
    output logic [NCH-1:0]  dack,
    output logic            hold_req,
    input  logic            hold_ack,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            io_rd,
    output logic            io_wr,
    output logic            tc
);
    logic [NCH-1:0][AW-1:0] addr_w;
    logic [NCH-1:0][CW-1:0] cnt_w;
    logic [NCH-1:0]         dir_w;
    logic [NCH-1:0]         mask_w;
    logic [NCH-1:0]         pend;
    logic                   pend_any;
    logic [CHW-1:0]         pend_idx;
    logic                   xfer;
    logic [CHW-1:0]         act;
    logic                   act_last;
    strobe_t                stb;

    dma4_regs #(
        .NCH(NCH), .AW(AW), .CW(CW), .DW(DW), .OFFW(OFFW), .CHW(CHW)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_off  (cfg_addr),
        .wr_data (cfg_wdata),
        .step    (xfer),
        .step_ch (act),
        .addr_o  (addr_w),
        .cnt_o   (cnt_w),
        .dir_o   (dir_w),
        .mask_o  (mask_w)
    );

    assign pend = dreq & ~mask_w;

    dma4_prio #(.NCH(NCH), .CHW(CHW)) u_prio (
        .req (pend),
        .any (pend_any),
        .idx (pend_idx)
    );

    assign act_last = (cnt_w[act] == '0);

    dma4_seq #(.CHW(CHW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pend_any (pend_any),
        .pend_idx (pend_idx),
        .hold_ack (hold_ack),
        .act_req  (dreq[act]),
        .act_last (act_last),
        .hold_req (hold_req),
        .xfer     (xfer),
        .act_idx  (act)
    );

    assign stb      = xfer ? strobes_for(dir_e'(dir_w[act])) : '0;
    assign mem_rd   = stb.mem_rd;
    assign mem_wr   = stb.mem_wr;
    assign io_rd    = stb.io_rd;
    assign io_wr    = stb.io_wr;
    assign dack     = xfer ? (NCH'(1) << act) : '0;
    assign mem_addr = xfer ? addr_w[act] : '0;
    assign tc       = xfer && act_last;
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] dack,
    input logic           hold_req,
    input logic           hold_ack,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic           tc
);
    // R11
    dack_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R11
    dack_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (|dack) == (mem_rd || mem_wr));

    // R5
    rd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd == io_wr);

    // R6
    wr_pair_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr == io_rd);

    // R5
    dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4
    dack_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> hold_req);

    // R4
    grant_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(|dack) |-> $past(hold_ack && hold_req));

    // R8
    tc_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> (|dack));

    // R8
    tc_release_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> (!hold_req && dack == '0));

    // R10
    drop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && ((dreq & dack) == '0)) |=> !hold_req);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((|dack) && $past(|dack) && dack == $past(dack))
            |-> mem_addr == $past(mem_addr) + AW'(1));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dreq     (dreq),
    .dack     (dack),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .tc       (tc)
);

// File: tb/dma4_ctrl_bench.sv
`timescale 1ns/1ps
module dma4_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        hold_req;
    logic        hold_ack = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, tc;
    logic [3:0]  stb;

    int vecs = 0;
    int bad  = 0;
    int cyc  = 0;

    assign stb = {mem_rd, mem_wr, io_rd, io_wr};

    dma4_ctrl u_dma4_ctrl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack),
        .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .tc(tc)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog cycles actual=%0d expected<=100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [7:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = 4'(off);
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c);
        wr(2 * ch, a[7:0]);
        wr(2 * ch, a[15:8]);
        wr(2 * ch + 1, c[7:0]);
        wr(2 * ch + 1, c[15:8]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        dreq = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [3:0] exp_stb(input int dir);
        return (dir != 0) ? 4'b0110 : 4'b1001;
    endfunction

    function automatic int idx_of(input logic [3:0] d);
        for (int i = 0; i < 4; i++)
            if (d[i]) return i;
        return -1;
    endfunction

    // Full burst on an already-programmed channel, bus granted at once.
    task automatic burst(input int ch, input logic [15:0] a, input int c,
                         input int dir, input string atag);
        @(negedge clk);
        dreq[ch] = 1'b1;
        @(negedge clk);
        chk(hold_req == 1'b1 && dack == '0, "R4", "hold raised before grant",
            {hold_req, dack}, {1'b1, 4'b0});
        @(negedge clk);
        for (int i = 0; i <= c; i++) begin
            chk(dack == 4'(1 << ch), "R11", "dack of active channel", dack, 4'(1 << ch));
            chk(mem_addr == 16'(a + i), atag, "transfer address", mem_addr, 16'(a + i));
            chk(stb == exp_stb(dir), (dir != 0) ? "R6" : "R5", "strobe pair",
                stb, exp_stb(dir));
            chk(tc == (i == c), "R8", "tc position", tc, (i == c));
            if (i == c) dreq[ch] = 1'b0;
            @(negedge clk);
        end
        chk(hold_req == 1'b0 && dack == '0, "R8", "bus released after tc",
            {hold_req, dack}, 5'b0);
    endtask

    task automatic wait_dack();
        for (int k = 0; k < 12 && dack == '0; k++) @(negedge clk);
    endtask

    initial begin
        int got [4];
        int n;
        logic [15:0] a;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk({hold_req, dack, stb, tc} == '0, "R1", "outputs in reset",
            {hold_req, dack, stb, tc}, 0);
        rst = 1'b0;
        dreq = 4'hF;
        repeat (4) begin
            @(negedge clk);
            chk({hold_req, dack, stb, tc} == '0, "R1", "channels disarmed after reset",
                {hold_req, dack, stb, tc}, 0);
        end
        dreq = '0;

        // R7 R5 R6: sweep channels, directions, counts with address wrap
        for (int ch = 0; ch < 4; ch++) begin
            for (int d = 0; d < 2; d++) begin
                for (int ci = 0; ci < 3; ci++) begin
                    int c;
                    c = (ci == 0) ? 0 : ((ci == 1) ? 1 : 3);
                    a = 16'(16'hFFFD + ch);
                    prog(ch, a, 16'(c));
                    wr(8, (d != 0) ? 8'(1 << ch) : 8'h00);
                    burst(ch, a, c, d, "R7");
                end
            end
        end

        // R8: disarmed after tc, re-armed only by count high byte
        wr(8, 8'h00);
        prog(2, 16'h2000, 16'h0000);
        burst(2, 16'h2000, 0, 0, "R7");
        @(negedge clk);
        dreq[2] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(hold_req == 1'b0, "R8", "request ignored after tc", hold_req, 0);
        end
        wr(5, 8'h01);
        @(negedge clk);
        chk(hold_req == 1'b0, "R8", "low count byte does not re-arm", hold_req, 0);
        wr(5, 8'h00);
        wait_dack();
        for (int i = 0; i < 2; i++) begin
            chk(mem_addr == 16'(16'h2001 + i), "R8", "re-armed burst address",
                mem_addr, 16'(16'h2001 + i));
            chk(tc == (i == 1), "R8", "re-armed tc", tc, (i == 1));
            if (i == 1) dreq[2] = 1'b0;
            @(negedge clk);
        end

        // R2 R3: direction and unused-offset writes between address bytes
        wr(0, 8'h78);
        wr(8, 8'h00);
        wr(13, 8'hFF);
        wr(0, 8'h56);
        wr(1, 8'h02);
        wr(11, 8'hFF);
        wr(1, 8'h00);
        burst(0, 16'h5678, 2, 0, "R3");

        // R3: reset clears the byte pointer
        wr(0, 8'hAA);
        do_reset();
        prog(0, 16'h1234, 16'h0000);
        burst(0, 16'h1234, 0, 0, "R3");

        // R2: device-to-memory bit position for channel 1 (bit 1 of offset 8)
        prog(1, 16'h0040, 16'h0000);
        wr(8, 8'h02);
        burst(1, 16'h0040, 0, 1, "R2");
        wr(8, 8'h00);

        // R4 R9: grant withheld; a lower channel arriving late wins at grant
        hold_ack = 1'b0;
        prog(3, 16'h0300, 16'h0000);
        prog(0, 16'h0000, 16'h0000);
        @(negedge clk);
        dreq[3] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(hold_req == 1'b1 && dack == '0 && stb == '0, "R4",
                "waiting for hold_ack", {hold_req, dack, stb}, 9'h100);
        end
        dreq[0] = 1'b1;
        @(negedge clk);
        hold_ack = 1'b1;
        n = 0;
        for (int k = 0; k < 20 && n < 2; k++) begin
            @(negedge clk);
            if (dack != '0) begin got[n] = idx_of(dack); n++; end
        end
        chk(n == 2 && got[0] == 0 && got[1] == 3, "R9", "late low channel wins at grant",
            {got[0][7:0], got[1][7:0]}, 16'h0003);
        dreq = '0;

        // R9: simultaneous pairs
        prog(1, 16'h0100, 16'h0001);
        prog(3, 16'h0300, 16'h0001);
        @(negedge clk);
        dreq = 4'b1010;
        n = 0;
        for (int k = 0; k < 30 && n < 4; k++) begin
            @(negedge clk);
            if (dack != '0) begin got[n] = idx_of(dack); n++; end
        end
        chk(n == 4 && got[0] == 1 && got[1] == 1 && got[2] == 3 && got[3] == 3, "R9",
            "order 1,1,3,3", {got[0][3:0], got[1][3:0], got[2][3:0], got[3][3:0]}, 16'h1133);
        dreq = '0;
        prog(0, 16'h0000, 16'h0000);
        prog(2, 16'h0200, 16'h0000);
        @(negedge clk);
        dreq = 4'b0101;
        n = 0;
        for (int k = 0; k < 30 && n < 2; k++) begin
            @(negedge clk);
            if (dack != '0) begin got[n] = idx_of(dack); n++; end
        end
        chk(n == 2 && got[0] == 0 && got[1] == 2, "R9", "order 0,2",
            {got[0][7:0], got[1][7:0]}, 16'h0002);
        dreq = '0;

        // R10: request drop mid-burst, then resume
        prog(0, 16'h4000, 16'h0009);
        @(negedge clk);
        dreq[0] = 1'b1;
        wait_dack();
        for (int i = 0; i < 3; i++) begin
            chk(mem_addr == 16'(16'h4000 + i), "R10", "address before drop",
                mem_addr, 16'(16'h4000 + i));
            if (i == 2) dreq[0] = 1'b0;
            @(negedge clk);
        end
        chk(hold_req == 1'b0 && dack == '0, "R10", "bus released on drop",
            {hold_req, dack}, 0);
        repeat (3) @(negedge clk);
        chk(dack == '0, "R10", "no transfer while dropped", dack, 0);
        dreq[0] = 1'b1;
        wait_dack();
        for (int i = 3; i <= 9; i++) begin
            chk(mem_addr == 16'(16'h4000 + i), "R10", "resumed address",
                mem_addr, 16'(16'h4000 + i));
            chk(tc == (i == 9), "R10", "resumed tc", tc, (i == 9));
            if (i == 9) dreq[0] = 1'b0;
            @(negedge clk);
        end
        chk(hold_req == 1'b0, "R10", "released after resumed tc", hold_req, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule